// File: doc/BRIEF.md
# Keyed Watchdog Timer

The block is a system watchdog around an 8-bit down-counter. Software arms it with a single control write that holds a start count, a command (start or stop) and a 7-bit key. Once running, the counter steps down by one on a slow tick. The tick comes from a prescaler that divides the system clock. The default division of 131072 turns a 100 MHz clock into a tick of roughly 763 Hz. Software keeps the system alive by sending start again before the count runs out. This is the kick, and it reloads the counter.

A write takes effect only if its key is the bitwise inverse of the key from the last accepted write. A stray loop that writes the same word over and over therefore cannot keep the watchdog alive, and it cannot stop it either. When the count steps down to 1, the block pulses a non-maskable interrupt request, which leaves software one tick to react. When the count reaches 0, the block drives a system reset for a fixed number of clocks and then returns to the stopped state.

Top module: `keyed_wdt`

## Requirements
- R1: After reset, count_o is 0, running_o is 0, nmi_o and wd_rst_o are 0, and the stored key is 0, so the first valid key is 0x7F.
- R2: A write is accepted only if wr_key_i equals the stored key XOR 0x7F and wd_rst_o is low. An accepted write's key becomes the new stored key.
- R3: A write with any other key has no effect on the count, the running state or the stored key.
- R4: An accepted write with wr_cmd_i = 1 (start) loads wr_cnt_i into the counter and sets running_o. A start while already running reloads the count.
- R5: An accepted write with wr_cmd_i = 0 (stop) clears running_o, and the count then holds its value.
- R6: While running, the count drops by one every PRESC_DIV clocks. The first drop comes exactly PRESC_DIV clocks after an accepted start, because every accepted start restarts the prescaler.
- R7: nmi_o is a one-cycle pulse in the cycle after the count steps from 2 to 1.
- R8: A tick at count 1 sets the count to 0 and drives wd_rst_o high for RST_HOLD clocks. The block is then stopped, and writes during that window are ignored.
- R9: A start with a count of 0 or 1 bites on the first tick without raising nmi_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Control write strobe |
| wr_cmd_i | input | 1 | 1 = start/kick, 0 = stop |
| wr_cnt_i | input | CNT_W | Start count |
| wr_key_i | input | KEY_W | Key; must be inverse of last accepted key |
| count_o | output | CNT_W | Current counter value |
| running_o | output | 1 | Watchdog running |
| nmi_o | output | 1 | Non-maskable interrupt request pulse |
| wd_rst_o | output | 1 | System reset request |

## Verification
The hardest state to reach from the ports is a write that arrives while the reset output is high, because the window only opens after a full countdown. To get there, the bench arms the watchdog with a short count under a small prescaler and waits for wd_rst_o. It then issues a write whose key would otherwise be valid, and after the window closes it checks that the block is still stopped. The same run also confirms that a kick landing mid-period restarts the tick phase and does not inherit it.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef enum logic {
    CMD_STOP  = 1'b0,
    CMD_START = 1'b1
  } wdt_cmd_e;
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int unsigned DIV = 131072
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic restart_i,
  output logic tick_o
);
  localparam int unsigned PW = (DIV > 2) ? $clog2(DIV) : 1;

  logic [PW-1:0] phase_q;

  assign tick_o = run_i && (phase_q == PW'(DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
    end else if (restart_i || !run_i || tick_o) begin
      phase_q <= '0;
    end else begin
      phase_q <= phase_q + 1'b1;
    end
  end
endmodule

// File: rtl/wdt_key_gate.sv
module wdt_key_gate #(
  parameter int unsigned KEY_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [KEY_W-1:0] key_i,
  input  logic             block_i,
  output logic             accept_o,
  output logic [KEY_W-1:0] key_o
);
  logic [KEY_W-1:0] key_q;

  assign accept_o = wr_en_i && !block_i && (key_i == ~key_q);
  assign key_o    = key_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       key_q <= '0;
    else if (accept_o) key_q <= key_i;
  end
endmodule

// File: rtl/wdt_core.sv
module wdt_core
  import wdt_pkg::*;
#(
  parameter int unsigned CNT_W    = 8,
  parameter int unsigned RST_HOLD = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             accept_i,
  input  wdt_cmd_e         cmd_i,
  input  logic [CNT_W-1:0] load_i,
  input  logic             tick_i,
  output logic [CNT_W-1:0] count_o,
  output logic             run_o,
  output logic             nmi_o,
  output logic             hold_o
);
  localparam int unsigned HW = $clog2(RST_HOLD + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             run_q;
  logic             nmi_q;
  logic [HW-1:0]    hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      run_q  <= 1'b0;
      nmi_q  <= 1'b0;
      hold_q <= '0;
    end else begin
      nmi_q <= 1'b0;
      if (hold_q != '0) begin
        hold_q <= hold_q - 1'b1;
      end else if (accept_i) begin
        if (cmd_i == CMD_START) begin
          cnt_q <= load_i;
          run_q <= 1'b1;
        end else begin
          run_q <= 1'b0;
        end
      end else if (run_q && tick_i) begin
        if (cnt_q <= CNT_W'(1)) begin
          // bite: counter expired
          cnt_q  <= '0;
          run_q  <= 1'b0;
          hold_q <= HW'(RST_HOLD);
        end else begin
          cnt_q <= cnt_q - 1'b1;
          nmi_q <= (cnt_q == CNT_W'(2));
        end
      end
    end
  end

  assign count_o = cnt_q;
  assign run_o   = run_q;
  assign nmi_o   = nmi_q;
  assign hold_o  = (hold_q != '0);
endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt
  import wdt_pkg::*;
#(
  parameter int unsigned CNT_W     = 8,
  parameter int unsigned KEY_W     = 7,
  parameter int unsigned PRESC_DIV = 131072,
  parameter int unsigned RST_HOLD  = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             wr_cmd_i,
  input  logic [CNT_W-1:0] wr_cnt_i,
  input  logic [KEY_W-1:0] wr_key_i,
  output logic [CNT_W-1:0] count_o,
  output logic             running_o,
  output logic             nmi_o,
  output logic             wd_rst_o
);
  logic             accept;
  logic             tick;
  logic             hold;
  logic [KEY_W-1:0] stored_key;
  wdt_cmd_e         cmd;

  assign cmd = wdt_cmd_e'(wr_cmd_i);

  wdt_key_gate #(.KEY_W(KEY_W)) i_key (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .key_i    (wr_key_i),
    .block_i  (hold),
    .accept_o (accept),
    .key_o    (stored_key)
  );

  wdt_prescaler #(.DIV(PRESC_DIV)) i_presc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (running_o),
    .restart_i (accept && (cmd == CMD_START)),
    .tick_o    (tick)
  );

  wdt_core #(.CNT_W(CNT_W), .RST_HOLD(RST_HOLD)) i_core (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .accept_i (accept),
    .cmd_i    (cmd),
    .load_i   (wr_cnt_i),
    .tick_i   (tick),
    .count_o  (count_o),
    .run_o    (running_o),
    .nmi_o    (nmi_o),
    .hold_o   (hold)
  );

  assign wd_rst_o = hold;
endmodule

// File: rtl/keyed_wdt_chk.sv
module keyed_wdt_chk #(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned KEY_W = 7
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic [KEY_W-1:0] wr_key_i,
  input logic [KEY_W-1:0] stored_key,
  input logic [CNT_W-1:0] count_o,
  input logic             running_o,
  input logic             nmi_o,
  input logic             wd_rst_o
);
  AST_WRONG_KEY_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && (wr_key_i != ~stored_key)) |=> $stable(stored_key)); // R3

  AST_STOPPED_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!running_o && !wd_rst_o && !wr_en_i) |=> $stable(count_o)); // R5

  AST_STEP_BY_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (running_o && !wr_en_i) |=> ((count_o == $past(count_o)) ||
                                 (count_o == CNT_W'($past(count_o) - 1'b1)) ||
                                 wd_rst_o)); // R6

  AST_NMI_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nmi_o |=> !nmi_o); // R7

  AST_NMI_AT_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nmi_o |-> (count_o == CNT_W'(1) && running_o)); // R7

  AST_RST_STOPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wd_rst_o |-> (!running_o && count_o == '0)); // R8

  AST_RST_BLOCKS_KEY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wd_rst_o |=> $stable(stored_key)); // R8
endmodule

bind keyed_wdt keyed_wdt_chk #(.CNT_W(CNT_W), .KEY_W(KEY_W)) i_keyed_wdt_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_en_i    (wr_en_i),
  .wr_key_i   (wr_key_i),
  .stored_key (stored_key),
  .count_o    (count_o),
  .running_o  (running_o),
  .nmi_o      (nmi_o),
  .wd_rst_o   (wd_rst_o)
);

// File: tb/test_keyed_wdt.sv
module test_keyed_wdt;
  localparam int DIV  = 8;
  localparam int HOLD = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic       wr_cmd = 1'b0;
  logic [7:0] wr_cnt = '0;
  logic [6:0] wr_key = '0;
  logic [7:0] count;
  logic       running, nmi, wd_rst;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // behavioural reference state
  int m_key = 0, m_cnt = 0, m_phase = 0, m_hold = 0;
  bit m_run = 0, m_nmi = 0;

  always #2 clk = ~clk;

  keyed_wdt #(.PRESC_DIV(DIV), .RST_HOLD(HOLD)) i_keyed_wdt (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_cmd_i(wr_cmd),
    .wr_cnt_i(wr_cnt), .wr_key_i(wr_key), .count_o(count),
    .running_o(running), .nmi_o(nmi), .wd_rst_o(wd_rst)
  );

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_key = 0; m_cnt = 0; m_phase = 0; m_hold = 0; m_run = 0; m_nmi = 0;
    end else begin
      bit acc, tk, r0;
      acc = wr_en && m_hold == 0 && int'(wr_key) == (m_key ^ 127);
      tk  = m_run && m_phase == DIV - 1;
      r0  = m_run;
      m_phase = ((acc && wr_cmd) || !r0 || tk) ? 0 : m_phase + 1;
      m_nmi = 0;
      if (m_hold > 0) m_hold--;
      else if (acc) begin
        m_key = wr_key;
        if (wr_cmd) begin m_cnt = wr_cnt; m_run = 1; end
        else m_run = 0;
      end else if (r0 && tk) begin
        if (m_cnt <= 1) begin m_cnt = 0; m_run = 0; m_hold = HOLD; end
        else begin m_cnt--; m_nmi = (m_cnt == 1); end
      end
    end
  end

  always @(negedge clk) if (rst_n && !done) begin
    check("R6 count", count, m_cnt);
    check("R4 running", running, m_run);
    check("R7 nmi", nmi, m_nmi);
    check("R8 wd_rst", wd_rst, m_hold > 0);
  end

  task automatic wr(bit cmd, int cnt, int key);
    @(negedge clk);
    wr_en = 1; wr_cmd = cmd; wr_cnt = 8'(cnt); wr_key = 7'(key);
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected completion");
    finish_run();
  end

  initial begin
    int n_nmi, n_rst, frozen;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 count", count, 0);
    check("R1 running", running, 0);
    check("R1 nmi", nmi, 0);
    check("R1 wd_rst", wd_rst, 0);

    wr(1, 5, 7'h11);
    check("R3 bad key start ignored", running, 0);
    wr(1, 5, 7'h7F);
    check("R2 key accepted", running, 1);
    check("R4 load", count, 5);
    repeat (8) @(negedge clk);
    check("R6 first tick", count, 4);
    repeat (8) @(negedge clk);
    check("R6 second tick", count, 3);
    repeat (3) @(negedge clk);
    wr(1, 5, 7'h00);
    check("R4 kick reload", count, 5);
    repeat (7) @(negedge clk);
    check("R6 prescaler restart", count, 5);
    @(negedge clk);
    check("R6 full period after kick", count, 4);

    wr(0, 0, 7'h00);
    check("R3 repeated key stop ignored", running, 1);
    wr(0, 0, 7'h7F);
    check("R5 stop", running, 0);
    frozen = count;
    repeat (30) @(negedge clk);
    check("R5 count frozen", count, frozen);

    wr(1, 3, 7'h00);
    n_nmi = 0;
    while (!wd_rst) begin
      @(negedge clk);
      if (nmi) n_nmi++;
    end
    check("R7 one nmi pulse", n_nmi, 1);
    wr(1, 9, 7'h7F);
    while (wd_rst) @(negedge clk);
    check("R8 write in reset ignored", running, 0);
    check("R8 count after reset", count, 0);

    wr(1, 1, 7'h7F);
    check("R2 key kept through reset", running, 1);
    n_nmi = 0; n_rst = 0;
    while (!wd_rst) begin
      @(negedge clk);
      if (nmi) n_nmi++;
    end
    while (wd_rst) begin
      n_rst++;
      @(negedge clk);
    end
    check("R9 no nmi from count 1", n_nmi, 0);
    check("R8 reset length", n_rst, HOLD);

    wr(1, 0, 7'h00);
    n_nmi = 0;
    while (!wd_rst) begin
      @(negedge clk);
      if (nmi) n_nmi++;
    end
    check("R9 no nmi from count 0", n_nmi, 0);
    while (wd_rst) @(negedge clk);
    @(negedge clk);
    finish_run();
  end
endmodule